// File: doc/BRIEF.md
# Command-Driven Control and Error Status Register

This block keeps the mode and error state of a serial controller in a single status word. It holds an enable flag, which selects configuration mode (0) or operational mode (1), a master-select flag and six sticky error flags. Software never writes these flags as values. Instead it writes a command word in which every flag has its own set bit and its own clear bit. A write therefore touches only the flags whose command bits are 1, and a single write can clear every error at once.

The shift engine reports faults through one pulse per error kind, and a pulse sets the matching flag. An error interrupt is raised as long as any error flag is set. The busy indication of the engine is shown in the status word without change. Register bus decode sits outside the block, which sees only a command strobe with its data word.

Top module: `ctlstat_reg`

## Requirements
- R1: After reset `statusWord` is 0 apart from bit 13 (busy), and `errIrq` is 0.
- R2: A command write takes effect at the clock edge that samples `cmdWr`. Command bit 0 clears the enable flag (status bit 0) and command bit 1 sets it.
- R3: Command bit 2 clears the master-select flag (status bit 1) and command bit 3 sets it.
- R4: The error flags sit in the status word as mode error at bit 7, transmit overflow at 8, receive overflow at 9, abort at 10, transmit underflow at 11 and receive underflow at 12. Command bits 4 and 5 clear and set receive underflow. Bits 6 and 7 clear and set mode error. Bits 8, 9, 10 and 11 clear transmit overflow, receive overflow, abort and transmit underflow, and bits 12, 13, 14 and 15 set those same four.
- R5: A single write with all six error clear bits set and no set bits returns all error flags to 0, provided no error pulse arrives in that cycle.
- R6: `errPulse` bits 0 to 5 set mode error, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. A pulse sets its flag at the next edge even when a clear of the same flag is written in that cycle.
- R7: When one write carries both the set bit and the clear bit of a flag, that flag keeps its previous value.
- R8: Without a command write or an error pulse, every flag holds its value, and an error flag stays set until it is cleared.
- R9: `errIrq` is 1 exactly when at least one of the six error flags is 1, and it changes in the same cycle as the flags.
- R10: Status bit 13 follows `busyIn` in the same cycle. Status bits 2 to 6, 14 and 15 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cmdWr | input | 1 | Command write strobe, valid for one cycle |
| cmdData | input | 16 | Command word with set and clear bits |
| errPulse | input | 6 | Error event pulses from the shift engine |
| busyIn | input | 1 | Busy indication from the shift engine |
| statusWord | output | 16 | Flags, busy and zero fill |
| errIrq | output | 1 | Error interrupt, OR of the error flags |

## Verification
The assertions assume that `cmdData` and `errPulse` are known whenever they are sampled. They also assume that a command is a one-cycle strobe whose effect appears at the next edge, with no retry or handshake. The stimulus gives every input a defined value in every cycle. It drives `cmdWr` as a single-cycle strobe at random density. It draws sparse error pulses, so that writes often meet pulses in the same cycle and both the sticky behaviour and the pulse-over-clear priority occur many times.

// File: rtl/ctlstat_pkg.sv
package ctlstat_pkg;
  localparam int CMD_W     = 16;
  localparam int STAT_W    = 16;
  localparam int NUM_ERR   = 6;
  localparam int NUM_CTRL  = 2;
  localparam int NUM_FLAGS = NUM_CTRL + NUM_ERR;

  // internal flag order: control flags first, then errors in status-bit order
  localparam int FLG_EN  = 0;
  localparam int FLG_MS  = 1;
  localparam int FLG_ME  = 2;
  localparam int FLG_TO  = 3;
  localparam int FLG_RO  = 4;
  localparam int FLG_AB  = 5;
  localparam int FLG_TU  = 6;
  localparam int FLG_RU  = 7;

  // status word layout
  localparam int ST_EN   = 0;
  localparam int ST_MS   = 1;
  localparam int ST_ERR0 = 7;
  localparam int ST_BUSY = 13;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setMask;
    logic [NUM_FLAGS-1:0] clrMask;
  } flagCmd_t;
endpackage

// File: rtl/ctlstat_cmd_decode.sv
module ctlstat_cmd_decode
  import ctlstat_pkg::*;
(
  input  logic             cmdWr,
  input  logic [CMD_W-1:0] cmdData,
  output flagCmd_t         cmdStb
);
  // command-word bit positions of each flag's clear/set pair
  localparam int CLR_POS [NUM_FLAGS] = '{0, 2, 6, 8, 9, 10, 11, 4};
  localparam int SET_POS [NUM_FLAGS] = '{1, 3, 7, 12, 13, 14, 15, 5};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
    assign cmdStb.setMask[i] = cmdWr & cmdData[SET_POS[i]];
    assign cmdStb.clrMask[i] = cmdWr & cmdData[CLR_POS[i]];
  end
endmodule

// File: rtl/ctlstat_flag_bank.sv
module ctlstat_flag_bank
  import ctlstat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  flagCmd_t             cmdStb,
  input  logic [NUM_FLAGS-1:0] hwSet,
  output logic [NUM_FLAGS-1:0] flags
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic doSet, doClr;
    assign doSet = cmdStb.setMask[i] & ~cmdStb.clrMask[i];
    assign doClr = cmdStb.clrMask[i] & ~cmdStb.setMask[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             flags[i] <= 1'b0;
      else if (hwSet[i])     flags[i] <= 1'b1;
      else if (doSet)        flags[i] <= 1'b1;
      else if (doClr)        flags[i] <= 1'b0;
    end

    AST_HW_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      hwSet[i] |=> flags[i]); // R6
    AST_CONFLICT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (cmdStb.setMask[i] && cmdStb.clrMask[i] && !hwSet[i]) |=> $stable(flags[i])); // R7
  end
endmodule

// File: rtl/ctlstat_reg.sv
module ctlstat_reg
  import ctlstat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [15:0]       cmdData,
  input  logic [5:0]        errPulse,
  input  logic              busyIn,
  output logic [15:0]       statusWord,
  output logic              errIrq
);
  flagCmd_t             cmdStb;
  logic [NUM_FLAGS-1:0] hwSet;
  logic [NUM_FLAGS-1:0] flags;

  ctlstat_cmd_decode u_dec (
    .cmdWr  (cmdWr),
    .cmdData(cmdData),
    .cmdStb (cmdStb)
  );

  assign hwSet = {errPulse, {NUM_CTRL{1'b0}}};

  ctlstat_flag_bank u_bank (
    .clk   (clk),
    .rstN  (rstN),
    .cmdStb(cmdStb),
    .hwSet (hwSet),
    .flags (flags)
  );

  always_comb begin
    statusWord = '0;
    statusWord[ST_EN] = flags[FLG_EN];
    statusWord[ST_MS] = flags[FLG_MS];
    statusWord[ST_ERR0 +: NUM_ERR] = flags[NUM_FLAGS-1:NUM_CTRL];
    statusWord[ST_BUSY] = busyIn;
  end

  assign errIrq = |flags[NUM_FLAGS-1:NUM_CTRL];

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[1] && !cmdData[0]) |=> statusWord[0]); // R2
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[0] && !cmdData[1]) |=> !statusWord[0]); // R2
  AST_MS_SET: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[3] && !cmdData[2]) |=> statusWord[1]); // R3
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[4] && cmdData[6] && (&cmdData[11:8]) && !cmdData[5]
     && !cmdData[7] && (cmdData[15:12] == 4'h0) && (errPulse == 6'h0)) |=> !errIrq); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdWr && (errPulse == 6'h0)) |=> $stable(statusWord[12:0])); // R8
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[6:2] == 5'h0) && (statusWord[15:14] == 2'h0)); // R10
endmodule

// File: tb/ctlstat_reg_tb.sv
module ctlstat_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWr = 1'b0;
  logic [15:0] cmdData = '0;
  logic [5:0]  errPulse = '0;
  logic        busyIn = 1'b0;
  logic [15:0] statusWord;
  logic        errIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state: [0]=enable [1]=master [2..7]=errors in status order 7..12
  logic [7:0] mFlags = '0;

  ctlstat_reg u_dut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData),
    .errPulse(errPulse), .busyIn(busyIn), .statusWord(statusWord), .errIrq(errIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int setBit(int f);
    case (f)
      0: return 1;  1: return 3;  2: return 7;  3: return 12;
      4: return 13; 5: return 14; 6: return 15; default: return 5;
    endcase
  endfunction

  function automatic int clrBit(int f);
    case (f)
      0: return 0;  1: return 2;  2: return 6;  3: return 8;
      4: return 9;  5: return 10; 6: return 11; default: return 4;
    endcase
  endfunction

  function automatic logic [7:0] nextFlags(logic [7:0] cur, logic wr,
                                           logic [15:0] d, logic [5:0] p);
    logic [7:0] n = cur;
    for (int f = 0; f < 8; f++) begin
      logic s, c, h;
      s = wr && d[setBit(f)];
      c = wr && d[clrBit(f)];
      h = (f >= 2) ? p[f-2] : 1'b0;
      if (h || (s && !c)) n[f] = 1'b1;
      else if (c && !s)   n[f] = 1'b0;
    end
    return n;
  endfunction

  function automatic logic [15:0] expStatus(logic [7:0] fl, logic b);
    logic [15:0] s = '0;
    s[0] = fl[0];
    s[1] = fl[1];
    s[12:7] = fl[7:2];
    s[13] = b;
    return s;
  endfunction

  task automatic checkOut(string tag);
    logic [15:0] es = expStatus(mFlags, busyIn);
    logic ei = |mFlags[7:2];
    checks++;
    if (statusWord !== es) begin
      errors++;
      $display("FAIL %s statusWord actual=%h expected=%h", tag, statusWord, es);
    end
    checks++;
    if (errIrq !== ei) begin
      errors++;
      $display("FAIL %s errIrq actual=%b expected=%b (R9)", tag, errIrq, ei);
    end
  endtask

  // called at a falling edge; applies inputs for one cycle, checks after the edge
  task automatic step(logic wr, logic [15:0] d, logic [5:0] p, logic b, string tag);
    cmdWr = wr; cmdData = d; errPulse = p; busyIn = b;
    @(posedge clk);
    mFlags = nextFlags(mFlags, wr, d, p);
    @(negedge clk);
    checkOut(tag);
    cmdWr = 1'b0; errPulse = '0;
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h1bad5eed);
    repeat (3) @(negedge clk);
    checkOut("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset release");

    step(1, 16'h0002, 6'h0, 0, "R2 enable set");
    step(1, 16'h0001, 6'h0, 1, "R2 enable clear, R10 busy");
    step(1, 16'h0008, 6'h0, 0, "R3 master set");
    step(1, 16'h0004, 6'h0, 0, "R3 master clear");
    step(1, 16'hF0A0, 6'h0, 0, "R4 set all errors");
    step(1, 16'h0F50, 6'h0, 0, "R5 clear all errors");
    step(1, 16'h0020, 6'h0, 0, "R4 receive underflow set");
    step(1, 16'h0010, 6'h0, 0, "R4 receive underflow clear");
    step(1, 16'h0000, 6'h01, 0, "R6 mode error pulse");
    step(1, 16'h0040, 6'h01, 0, "R6 pulse beats clear");
    step(0, 16'h0000, 6'h0, 0, "R8 sticky hold");
    step(1, 16'h00C0, 6'h0, 0, "R7 mode set and clear together");
    step(1, 16'h000A, 6'h0, 0, "R7 precondition enable and master");
    step(1, 16'h000F, 6'h0, 0, "R7 both pairs conflict");
    step(1, 16'h0F50, 6'h20, 0, "R6 pulse during clear-all");
    step(1, 16'h0F50, 6'h0, 1, "R5 clear-all after pulse");

    for (int i = 0; i < 600; i++) begin
      logic [5:0] p;
      p = '0;
      for (int k = 0; k < 6; k++) p[k] = ($urandom % 12) == 0;
      step(($urandom % 3) == 0, 16'($urandom), p, 1'($urandom), "R8 R9 random");
    end

    step(1, 16'h0F50, 6'h0, 0, "R5 final clear");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule